// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snooping Data Cache

This block is a private, direct-mapped data cache that serves one core. It stays coherent with identical caches that share an atomic bus, which carries one transaction at a time, in order. Each line holds one word, a tag and a single coherence bit that reads either Valid or Invalid. The core sends loads and stores over a valid/ready request channel and receives one response for each request. A load miss fetches the word over the bus and installs it. Every store goes through to memory as a bus write. A store never allocates a line. It refreshes a line only when it hits.

In every cycle the cache also watches the shared bus. A write from any other master that matches a line the cache holds as Valid clears that line. The cache's own transaction is marked by its grant and is never treated as a snoop. Only one request is outstanding at a time. The processor request channel stalls from the moment a request is accepted until its response has been taken. Back-pressure rules: a request is accepted in a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Once `cpu_rsp_valid` is raised, it stays high with stable data until `cpu_rsp_ready` is seen high. The bus request has no back-pressure of its own. It is held steady until the grant pulse.

Top module: `snoopy_vi_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is 1, `bus_req` is 0 and `cpu_rsp_valid` is 0.
- R2: A load whose line is Invalid or holds another tag raises a bus read (`bus_req_wr`=0). On the grant it installs `bus_rdata` as Valid and returns that word.
- R3: A load that finds a Valid line with a matching tag returns the cached word and raises no bus request.
- R4: Every store raises a bus write (`bus_req_wr`=1) carrying the store's address and data. A store that hits leaves the line Valid holding the new word, and the store response returns the stored data.
- R5: A store that misses writes memory only. The line stays Invalid or keeps its old tag, so the next load of that address goes to the bus.
- R6: When the bus shows a write from another master (`bus_vld`=1, `bus_wr`=1, `bus_gnt`=0) whose address matches a Valid line, that line becomes Invalid. A foreign read, or a foreign write to the same index with another tag, leaves the line untouched.
- R7: The cache's own granted transaction is never snooped, so a store hit stays Valid after its own bus write.
- R8: Address bits [INDEX_W-1:0] select the line and the upper bits form the tag. A load of a different tag at the same index replaces the line.
- R9: `cpu_req_ready` drops in the cycle after a request is accepted and stays low until the response is taken. This includes the whole wait for the grant.
- R10: `cpu_rsp_valid` stays high with a stable `cpu_rsp_data` until `cpu_rsp_ready` is 1.
- R11: `bus_req` and its address, command and data stay stable until `bus_gnt`. The transaction completes in the grant cycle, with read data sampled in that same cycle.
- R12: A load accepted in the same cycle as a matching foreign bus write counts as a miss and returns the new memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Response present |
| cpu_rsp_ready | input | 1 | Processor takes the response |
| cpu_rsp_data | output | DATA_W | Load data, or the stored word |
| bus_req | output | 1 | Bus transaction requested |
| bus_req_wr | output | 1 | 1 = bus write, 0 = bus read |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write data |
| bus_gnt | input | 1 | One-cycle grant; own transaction happens this cycle |
| bus_rdata | input | DATA_W | Memory read data in the grant cycle |
| bus_vld | input | 1 | A transaction is on the shared bus |
| bus_wr | input | 1 | Shared bus transaction is a write |
| bus_addr | input | ADDR_W | Shared bus address |

## Verification
The bench sweeps loads over every address of the 8-bit space, so each index sees tag conflicts. A cache that compared too few tag bits would return a neighbour's word. It then pairs store hits with store misses. A cache that allocated on a store miss would skip the bus on the next load. A cache that snooped its own write would lose the line it had just updated. Foreign reads, foreign writes to the same index with another tag, and matching foreign writes check that only an exact write match invalidates. A cache that ignored snoops would hand back the stale word. The bench also lands a snoop in the very cycle a load is accepted, which catches a hit decided on pre-snoop state. Delayed grants and a held response check that the request is stalled and the outputs stay steady.

// File: rtl/snoopy_vi_pkg.sv
package snoopy_vi_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_BUS  = 2'd1,
    CS_RSP  = 2'd2
  } ctrl_state_e;
endpackage

// File: rtl/vi_line_store.sv
module vi_line_store #(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 5,
  parameter int DATA_W  = 16,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_vld,
  output logic [TAG_W-1:0]   rd_tag,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [INDEX_W-1:0] snp_idx,
  output logic               snp_vld,
  output logic [TAG_W-1:0]   snp_tag,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0]   wr_tag,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               inv_en,
  input  logic [INDEX_W-1:0] inv_idx
);
  logic [LINES-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end else if (wr_en && (wr_idx == INDEX_W'(i))) begin
        vld_q[i] <= 1'b1;
        tag_q[i] <= wr_tag;
        dat_q[i] <= wr_data;
      end else if (inv_en && (inv_idx == INDEX_W'(i))) begin
        vld_q[i] <= 1'b0;
      end
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = dat_q[rd_idx];
  assign snp_vld = vld_q[snp_idx];
  assign snp_tag = tag_q[snp_idx];

  // R6: a snoop kill leaves the line Invalid on the next cycle
  a_r6_kill_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_en && wr_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/vi_snoop_unit.sv
module vi_snoop_unit #(
  parameter int ADDR_W  = 8,
  parameter int INDEX_W = 3,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic               bus_vld,
  input  logic               bus_wr,
  input  logic               bus_gnt,
  input  logic [ADDR_W-1:0]  bus_addr,
  output logic [INDEX_W-1:0] snp_idx,
  input  logic               line_vld,
  input  logic [TAG_W-1:0]   line_tag,
  output logic               inv_en,
  output logic [INDEX_W-1:0] inv_idx
);
  logic             foreign_wr;
  logic [TAG_W-1:0] bus_tag;

  assign snp_idx    = bus_addr[INDEX_W-1:0];
  assign bus_tag    = bus_addr[ADDR_W-1:INDEX_W];
  assign foreign_wr = bus_vld && bus_wr && !bus_gnt;
  assign inv_en     = foreign_wr && line_vld && (line_tag == bus_tag);
  assign inv_idx    = snp_idx;
endmodule

// File: rtl/vi_cache_ctrl.sv
module vi_cache_ctrl
  import snoopy_vi_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 3,
  localparam int TAG_W  = ADDR_W - INDEX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  output logic               cpu_req_ready,
  input  logic               cpu_req_we,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  output logic               cpu_rsp_valid,
  input  logic               cpu_rsp_ready,
  output logic [DATA_W-1:0]  cpu_rsp_data,
  output logic               bus_req,
  output logic               bus_req_wr,
  output logic [ADDR_W-1:0]  bus_req_addr,
  output logic [DATA_W-1:0]  bus_req_wdata,
  input  logic               bus_gnt,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic [INDEX_W-1:0] lookup_idx,
  input  logic               lookup_vld,
  input  logic [TAG_W-1:0]   lookup_tag,
  input  logic [DATA_W-1:0]  lookup_data,
  input  logic               kill_en,
  input  logic [INDEX_W-1:0] kill_idx,
  output logic               wr_en,
  output logic [INDEX_W-1:0] wr_idx,
  output logic [TAG_W-1:0]   wr_tag,
  output logic [DATA_W-1:0]  wr_data
);
  ctrl_state_e       state_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rsp_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit;
  logic              accept;

  assign cur_addr   = (state_q == CS_IDLE) ? cpu_req_addr : addr_q;
  assign lookup_idx = cur_addr[INDEX_W-1:0];
  assign cur_tag    = cur_addr[ADDR_W-1:INDEX_W];
  // a kill landing this cycle wins over the lookup
  assign hit = lookup_vld && (lookup_tag == cur_tag) &&
               !(kill_en && (kill_idx == lookup_idx));

  assign cpu_req_ready = (state_q == CS_IDLE);
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign cpu_rsp_valid = (state_q == CS_RSP);
  assign cpu_rsp_data  = rsp_q;

  assign bus_req       = (state_q == CS_BUS);
  assign bus_req_wr    = we_q;
  assign bus_req_addr  = addr_q;
  assign bus_req_wdata = wdata_q;

  // fill on read grant, refresh on write grant only when the line still hits
  assign wr_en   = (state_q == CS_BUS) && bus_gnt && (!we_q || hit);
  assign wr_idx  = addr_q[INDEX_W-1:0];
  assign wr_tag  = addr_q[ADDR_W-1:INDEX_W];
  assign wr_data = we_q ? wdata_q : bus_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= '0;
    end else begin
      case (state_q)
        CS_IDLE: begin
          if (accept) begin
            we_q    <= cpu_req_we;
            addr_q  <= cpu_req_addr;
            wdata_q <= cpu_req_wdata;
            if (!cpu_req_we && hit) begin
              rsp_q   <= lookup_data;
              state_q <= CS_RSP;
            end else begin
              state_q <= CS_BUS;
            end
          end
        end
        CS_BUS: begin
          if (bus_gnt) begin
            rsp_q   <= we_q ? wdata_q : bus_rdata;
            state_q <= CS_RSP;
          end
        end
        CS_RSP: begin
          if (cpu_rsp_ready) state_q <= CS_IDLE;
        end
        default: state_q <= CS_IDLE;
      endcase
    end
  end

  // R9: one outstanding request
  a_r9_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cpu_req_ready);
  // R10: response held under back-pressure
  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_data)));
  // R11: bus request steady until granted
  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_req_addr) &&
                               $stable(bus_req_wr) && $stable(bus_req_wdata)));
  // R11: grant only meaningful while requesting
  a_r11_gnt_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> bus_req);
  // R3: a load hit never reaches the bus
  a_r3_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_req_we && hit) |=> (!bus_req && cpu_rsp_valid));
endmodule

// File: rtl/snoopy_vi_cache.sv
module snoopy_vi_cache #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int INDEX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_data,
  output logic              bus_req,
  output logic              bus_req_wr,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] lookup_idx;
  logic               lookup_vld;
  logic [TAG_W-1:0]   lookup_tag;
  logic [DATA_W-1:0]  lookup_data;
  logic [INDEX_W-1:0] snp_idx;
  logic               snp_vld;
  logic [TAG_W-1:0]   snp_tag;
  logic               kill_en;
  logic [INDEX_W-1:0] kill_idx;
  logic               wr_en;
  logic [INDEX_W-1:0] wr_idx;
  logic [TAG_W-1:0]   wr_tag;
  logic [DATA_W-1:0]  wr_data;

  vi_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (lookup_idx),
    .rd_vld  (lookup_vld),
    .rd_tag  (lookup_tag),
    .rd_data (lookup_data),
    .snp_idx (snp_idx),
    .snp_vld (snp_vld),
    .snp_tag (snp_tag),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_tag  (wr_tag),
    .wr_data (wr_data),
    .inv_en  (kill_en),
    .inv_idx (kill_idx)
  );

  vi_snoop_unit #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_snoop (
    .bus_vld  (bus_vld),
    .bus_wr   (bus_wr),
    .bus_gnt  (bus_gnt),
    .bus_addr (bus_addr),
    .snp_idx  (snp_idx),
    .line_vld (snp_vld),
    .line_tag (snp_tag),
    .inv_en   (kill_en),
    .inv_idx  (kill_idx)
  );

  vi_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_we    (cpu_req_we),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_ready (cpu_rsp_ready),
    .cpu_rsp_data  (cpu_rsp_data),
    .bus_req       (bus_req),
    .bus_req_wr    (bus_req_wr),
    .bus_req_addr  (bus_req_addr),
    .bus_req_wdata (bus_req_wdata),
    .bus_gnt       (bus_gnt),
    .bus_rdata     (bus_rdata),
    .lookup_idx    (lookup_idx),
    .lookup_vld    (lookup_vld),
    .lookup_tag    (lookup_tag),
    .lookup_data   (lookup_data),
    .kill_en       (kill_en),
    .kill_idx      (kill_idx),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_tag        (wr_tag),
    .wr_data       (wr_data)
  );

  // R7: own granted write is not snooped, so a hit line survives it
  a_r7_no_self_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_vld && bus_wr && wr_en) |=> lookup_vld || (lookup_idx != $past(wr_idx)));
endmodule

// File: tb/snoopy_vi_cache_tb_top.sv
module snoopy_vi_cache_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0, cpu_rsp_ready = 1'b1;
  logic [7:0]  cpu_req_addr = '0;
  logic [15:0] cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [15:0] cpu_rsp_data;
  logic        bus_req, bus_req_wr;
  logic [7:0]  bus_req_addr;
  logic [15:0] bus_req_wdata;
  logic        bus_gnt = 1'b0, bus_vld = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_rdata = '0;
  logic [7:0]  bus_addr = '0;

  snoopy_vi_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_data(cpu_rsp_data),
    .bus_req(bus_req), .bus_req_wr(bus_req_wr), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .bus_vld(bus_vld), .bus_wr(bus_wr), .bus_addr(bus_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] mem [256];
  bit          mv [8];
  logic [4:0]  mt [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // one processor operation against the reference memory and line model
  task automatic do_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                       input bit snp_same, input logic [15:0] snp_d,
                       input int gdelay, input bit hold, input string lbl);
    logic [2:0]  idx = a[2:0];
    logic [4:0]  tg  = a[7:3];
    bit          exp_bus, used, done, hit_m;
    int          waited, guard;
    logic [15:0] got, expd;
    string       r;
    used = 0; done = 0; waited = 0; guard = 0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    cpu_rsp_ready = hold ? 1'b0 : 1'b1;
    if (snp_same) begin
      bus_vld = 1; bus_wr = 1; bus_addr = a;
      if (mv[idx] && mt[idx] == tg) mv[idx] = 0;
      mem[a] = snp_d;
    end
    hit_m = mv[idx] && (mt[idx] == tg);
    exp_bus = we || !hit_m;
    @(posedge clk);
    while (!done && guard < 100) begin
      guard++;
      @(negedge clk);
      cpu_req_valid = 0; bus_gnt = 0; bus_vld = 0; bus_wr = 0;
      if (bus_req) begin
        if (waited < gdelay) begin
          waited++;
          chk(cpu_req_ready == 1'b0, "R9", 32'(cpu_req_ready), 0);
        end else begin
          chk(bus_req_wr == we && bus_req_addr == a, "R11", {bus_req_wr, bus_req_addr}, {we, a});
          if (we) chk(bus_req_wdata == wd, "R4", 32'(bus_req_wdata), 32'(wd));
          bus_gnt = 1; bus_vld = 1; bus_wr = we; bus_addr = a; bus_rdata = mem[a];
          used = 1;
          @(posedge clk);
          if (we) mem[a] = wd;
        end
      end else if (cpu_rsp_valid) begin
        got = cpu_rsp_data;
        if (hold) begin
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(cpu_rsp_valid && cpu_rsp_data == got, "R10", 32'(cpu_rsp_data), 32'(got));
          end
          cpu_rsp_ready = 1;
        end
        @(posedge clk);
        done = 1;
      end
    end
    expd = we ? wd : mem[a];
    if (lbl != "") r = lbl;
    else if (we) r = hit_m ? "R4" : "R5";
    else r = hit_m ? "R3" : "R2";
    chk(done && got == expd, r, 32'(got), 32'(expd));
    chk(used == exp_bus, r, 32'(used), 32'(exp_bus));
    if (!we) begin mv[idx] = 1; mt[idx] = tg; end
  endtask

  task automatic foreign(input bit we, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_vld = 1; bus_wr = we; bus_addr = a;
    @(posedge clk);
    if (we) begin
      if (mv[a[2:0]] && mt[a[2:0]] == a[7:3]) mv[a[2:0]] = 0;
      mem[a] = d;
    end
    @(negedge clk);
    bus_vld = 0; bus_wr = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'((i * 37 + 5) & 16'hFFFF);
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_req_ready == 1 && bus_req == 0 && cpu_rsp_valid == 0, "R1",
        {cpu_req_ready, bus_req, cpu_rsp_valid}, 3'b100);
    // R1, R2, R3, R8: full address sweep, miss then hit
    for (int a = 0; a < 256; a++) begin
      do_op(0, 8'(a), 0, 0, 0, 0, 0, (a < 8) ? "R1" : "");
      do_op(0, 8'(a), 0, 0, 0, 0, 0, "");
    end
    // R4, R5, R7, R8: store hit, store miss, conflict eviction
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a = 8'(i * 8 + 3);
      logic [7:0] b = a ^ 8'h40;
      do_op(0, a, 0, 0, 0, 0, 0, "");
      do_op(1, a, 16'hA000 + 16'(i), 0, 0, 0, 0, "R4");
      do_op(0, a, 0, 0, 0, 0, 0, "R7");
      do_op(1, b, 16'hB000 + 16'(i), 0, 0, 0, 0, "R5");
      do_op(0, a, 0, 0, 0, 0, 0, "R5");
      do_op(0, b, 0, 0, 0, 0, 0, "R8");
      do_op(0, a, 0, 0, 0, 0, 0, "R8");
    end
    // R6: foreign traffic
    for (int i = 0; i < 8; i++) begin
      logic [7:0] a = 8'(i + 8'h90);
      do_op(0, a, 0, 0, 0, 0, 0, "");
      foreign(0, a, 0);
      do_op(0, a, 0, 0, 0, 0, 0, "R6");
      foreign(1, a ^ 8'h08, 16'hC000 + 16'(i));
      do_op(0, a, 0, 0, 0, 0, 0, "R6");
      foreign(1, a, 16'hD000 + 16'(i));
      do_op(0, a, 0, 0, 0, 0, 0, "R6");
    end
    // R9, R11: delayed grants; R10: held response
    do_op(0, 8'h21, 0, 0, 0, 4, 0, "R9");
    do_op(1, 8'h21, 16'h1234, 0, 0, 3, 1, "R10");
    do_op(0, 8'h21, 0, 0, 0, 0, 1, "R10");
    // R12: snoop in the acceptance cycle
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a = 8'(8'h60 + i);
      do_op(0, a, 0, 0, 0, 0, 0, "");
      do_op(0, a, 0, 1, 16'hE000 + 16'(i), 0, 0, "R12");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule